// File: doc/BRIEF.md
# Packed-Lane Compare and Predicate Set

This block compares one sub-word lane taken from each of two 32-bit operand words and turns the outcome into a pair of predicate bits. Each operand lane can be a byte, a halfword or the full word. The lane is zero- or sign-extended according to its own select code. Operand B can instead come from a 16-bit immediate. A 3-bit condition code chooses the relation to test.

The raw compare result and its complement are each merged with a source predicate through a selectable boolean operation. The source predicate can be inverted first. Both merged bits are registered together with a valid flag, one cycle after an accepted request. The surrounding pipeline writes them to its predicate storage. The compare is exact for every mix of signedness and lane width: an unsigned full word is never read as negative, and a signed lane is never read as large and positive.

Top module: `lane_cmp_pred`

## Requirements
- R1: Select code bits [2:0] choose the lane: 0 to 3 pick byte k (bits 8k+7 to 8k), 4 picks bits 15:0, 5 picks bits 31:16, and 6 or 7 pick the whole word. Bit 3 set means the lane is signed and is sign-extended; clear means it is zero-extended.
- R2: When `b_is_reg` is 0, B is the 16-bit immediate. It is sign-extended when `sel_b[3]` is 1 and zero-extended otherwise. `sel_b[2:0]` and `op_b` have no effect on the result.
- R3: When both lanes have the same signedness, the compare is signed when both are signed and unsigned when both are unsigned.
- R4: When the signedness differs, the compare is exact on the true integer values, including full-word lanes.
- R5: `cond` encodes 0 never, 1 less-than, 2 equal, 3 less-or-equal, 4 greater-than, 5 not-equal, 6 greater-or-equal and 7 always, comparing A against B.
- R6: `pred_f` is formed from the complement of the compare result. `pred_t` is formed from the result itself.
- R7: The effective source predicate is `src_pred` XOR `src_pred_inv`. `bool_op` 0 means AND, 1 means OR, 2 means XOR and 3 means AND. The operation is applied to each raw bit and the effective source predicate.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the predicates for that request appear in the same cycle.
- R9: While `in_valid` is low, `pred_t` and `pred_f` keep their last values.
- R10: Synchronous reset clears `out_valid`, `pred_t` and `pred_f`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Operand A word |
| op_b | input | 32 | Operand B word |
| imm_b | input | 16 | Immediate value used for B |
| b_is_reg | input | 1 | 1: B from `op_b`; 0: B from `imm_b` |
| sel_a | input | 4 | Lane select and signedness for A |
| sel_b | input | 4 | Lane select and signedness for B |
| cond | input | 3 | Condition code |
| bool_op | input | 2 | Boolean merge operation |
| src_pred | input | 1 | Source predicate |
| src_pred_inv | input | 1 | Invert the source predicate |
| out_valid | output | 1 | Result valid |
| pred_t | output | 1 | Merged compare result |
| pred_f | output | 1 | Merged complement of the compare result |

## Verification
Every result is due at the first rising edge after the edge that accepts `in_valid`. `out_valid`, `pred_t` and `pred_f` all change together at that edge. The bench drives each request on a falling edge and reads the outputs on the next falling edge, halfway through the cycle in which they are due. A directed test also reads `out_valid` in the half cycle before that edge, where it must still be low. The hold and reset checks sample on falling edges across several idle cycles, so each check sees exactly one register update.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;

    localparam int SEL_W  = 4;
    localparam int COND_W = 3;
    localparam int BOP_W  = 2;

    // lane field codes held in select bits [2:0]
    localparam logic [2:0] LANE_HALF_LO = 3'd4;
    localparam logic [2:0] LANE_HALF_HI = 3'd5;

    typedef enum logic [COND_W-1:0] {
        CC_NEVER  = 3'd0,
        CC_LT     = 3'd1,
        CC_EQ     = 3'd2,
        CC_LE     = 3'd3,
        CC_GT     = 3'd4,
        CC_NE     = 3'd5,
        CC_GE     = 3'd6,
        CC_ALWAYS = 3'd7
    } cmp_cond_e;

    typedef enum logic [BOP_W-1:0] {
        BOP_AND     = 2'd0,
        BOP_OR      = 2'd1,
        BOP_XOR     = 2'd2,
        BOP_AND_ALT = 2'd3
    } pred_bop_e;

    typedef struct packed {
        logic vld;
        logic p_t;
        logic p_f;
    } pred_state_t;

endpackage

// File: rtl/lane_cmp_extract.sv
module lane_cmp_extract
    import lane_cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W:0]   lane_o
);
    localparam int N_BYTE = 4;
    localparam int N_HALF = 2;
    localparam int BYTE_W = DATA_W / N_BYTE;
    localparam int HALF_W = DATA_W / N_HALF;

    logic              is_signed;
    logic [DATA_W:0]   byte_ext [N_BYTE];
    logic [DATA_W:0]   half_ext [N_HALF];
    logic [DATA_W:0]   word_ext;

    assign is_signed = sel_i[SEL_W-1];

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        assign byte_ext[k] = {{(DATA_W+1-BYTE_W){is_signed & word_i[k*BYTE_W+BYTE_W-1]}},
                              word_i[k*BYTE_W +: BYTE_W]};
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign half_ext[h] = {{(DATA_W+1-HALF_W){is_signed & word_i[h*HALF_W+HALF_W-1]}},
                              word_i[h*HALF_W +: HALF_W]};
    end

    assign word_ext = {is_signed & word_i[DATA_W-1], word_i};

    always_comb begin
        if (sel_i[2] == 1'b0) begin
            lane_o = byte_ext[sel_i[1:0]];
        end else if (sel_i[2:0] == LANE_HALF_LO) begin
            lane_o = half_ext[0];
        end else if (sel_i[2:0] == LANE_HALF_HI) begin
            lane_o = half_ext[1];
        end else begin
            lane_o = word_ext;
        end
    end

endmodule

// File: rtl/lane_cmp_compare.sv
module lane_cmp_compare
    import lane_cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W:0]   a_i,
    input  logic [DATA_W:0]   b_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              hit_o
);
    logic lt, eq, gt;

    // one extra bit keeps each operand's own signedness exact
    assign lt = $signed(a_i) < $signed(b_i);
    assign eq = (a_i == b_i);
    assign gt = ~lt & ~eq;

    // condition bits: [0] accepts less, [1] accepts equal, [2] accepts greater
    assign hit_o = |(cond_i & {gt, eq, lt});

endmodule

// File: rtl/lane_cmp_combine.sv
module lane_cmp_combine
    import lane_cmp_pkg::*;
(
    input  logic             hit_i,
    input  logic             src_pred_i,
    input  logic             src_inv_i,
    input  logic [BOP_W-1:0] bop_i,
    output logic             pred_t_o,
    output logic             pred_f_o
);
    logic eff_pred;
    logic raw [2];
    logic merged [2];

    assign eff_pred = src_pred_i ^ src_inv_i;
    assign raw[0]   = hit_i;
    assign raw[1]   = ~hit_i;

    for (genvar i = 0; i < 2; i++) begin : g_merge
        always_comb begin
            case (pred_bop_e'(bop_i))
                BOP_OR:  merged[i] = raw[i] | eff_pred;
                BOP_XOR: merged[i] = raw[i] ^ eff_pred;
                default: merged[i] = raw[i] & eff_pred;
            endcase
        end
    end

    assign pred_t_o = merged[0];
    assign pred_f_o = merged[1];

endmodule

// File: rtl/lane_cmp_pred.sv
module lane_cmp_pred
    import lane_cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm_b,
    input  logic              b_is_reg,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    input  logic [COND_W-1:0] cond,
    input  logic [BOP_W-1:0]  bool_op,
    input  logic              src_pred,
    input  logic              src_pred_inv,
    output logic              out_valid,
    output logic              pred_t,
    output logic              pred_f
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] a_lane, b_lane, b_imm, b_val;
    logic             hit, nxt_t, nxt_f;
    pred_state_t      state_d, state_q;

    lane_cmp_extract #(.DATA_W(DATA_W)) u_ext_a (
        .word_i (op_a),
        .sel_i  (sel_a),
        .lane_o (a_lane)
    );

    lane_cmp_extract #(.DATA_W(DATA_W)) u_ext_b (
        .word_i (op_b),
        .sel_i  (sel_b),
        .lane_o (b_lane)
    );

    assign b_imm = {{(EXT_W-IMM_W){sel_b[SEL_W-1] & imm_b[IMM_W-1]}}, imm_b};
    assign b_val = b_is_reg ? b_lane : b_imm;

    lane_cmp_compare #(.DATA_W(DATA_W)) u_cmp (
        .a_i    (a_lane),
        .b_i    (b_val),
        .cond_i (cond),
        .hit_o  (hit)
    );

    lane_cmp_combine u_comb (
        .hit_i      (hit),
        .src_pred_i (src_pred),
        .src_inv_i  (src_pred_inv),
        .bop_i      (bool_op),
        .pred_t_o   (nxt_t),
        .pred_f_o   (nxt_f)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.p_t = nxt_t;
            state_d.p_f = nxt_f;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign pred_t    = state_q.p_t;
    assign pred_f    = state_q.p_f;

endmodule

module lane_cmp_pred_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] cond,
    input logic [1:0] bool_op,
    input logic       src_pred,
    input logic       src_pred_inv,
    input logic       out_valid,
    input logic       pred_t,
    input logic       pred_f
);
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && !pred_t && !pred_f));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pred_t) && $stable(pred_f)));

    assert_xor_complement_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bool_op == 2'd2) |=> (pred_t != pred_f));

    assert_and_zero_pred_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bool_op != 2'd1 && bool_op != 2'd2 && src_pred == src_pred_inv)
        |=> (!pred_t && !pred_f));

    assert_or_one_pred_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bool_op == 2'd1 && src_pred != src_pred_inv) |=> (pred_t && pred_f));

    assert_never_cond_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 3'd0 && bool_op == 2'd0) |=> !pred_t);

    assert_always_cond_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 3'd7 && bool_op == 2'd0 && src_pred != src_pred_inv)
        |=> (pred_t && !pred_f));
endmodule

bind lane_cmp_pred lane_cmp_pred_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .cond         (cond),
    .bool_op      (bool_op),
    .src_pred     (src_pred),
    .src_pred_inv (src_pred_inv),
    .out_valid    (out_valid),
    .pred_t       (pred_t),
    .pred_f       (pred_f)
);

// File: tb/lane_cmp_pred_tb.sv
module lane_cmp_pred_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [15:0] imm_b = '0;
    logic        b_is_reg = 1'b1;
    logic [3:0]  sel_a = '0, sel_b = '0;
    logic [2:0]  cond = '0;
    logic [1:0]  bool_op = '0;
    logic        src_pred = 1'b0, src_pred_inv = 1'b0;
    logic        out_valid, pred_t, pred_f;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    lane_cmp_pred dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .imm_b(imm_b), .b_is_reg(b_is_reg), .sel_a(sel_a), .sel_b(sel_b),
        .cond(cond), .bool_op(bool_op), .src_pred(src_pred),
        .src_pred_inv(src_pred_inv), .out_valid(out_valid), .pred_t(pred_t),
        .pred_f(pred_f)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        breg;
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic [2:0]  cc;
        logic [1:0]  bop;
        logic        pr;
        logic        pi;
        logic        et;
        logic        ef;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // R3: unsigned bytes 240 > 16
        '{32'h000000F0, 32'h00000010, 16'h0, 1'b1, 4'd0, 4'd0, 3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},
        // R3: signed bytes -16 > 16 is false
        '{32'h000000F0, 32'h00000010, 16'h0, 1'b1, 4'd8, 4'd8, 3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},
        // R1: byte3 of A equals byte2 of B
        '{32'h12345678, 32'h00120000, 16'h0, 1'b1, 4'd3, 4'd2, 3'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
        // R4: signed word -2^31 < unsigned word 1
        '{32'h80000000, 32'h00000001, 16'h0, 1'b1, 4'd14, 4'd6, 3'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
        // R4: unsigned word 2^32-1 > signed byte -1
        '{32'hFFFFFFFF, 32'h000000FF, 16'h0, 1'b1, 4'd6, 4'd8, 3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
        // R4: signed byte1 -1 >= unsigned byte2 255 is false
        '{32'h0000FF00, 32'h00FF0000, 16'h0, 1'b1, 4'd9, 4'd2, 3'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},
        // R1: signed high half -32768 <= signed low half 32767
        '{32'h80000000, 32'h00007FFF, 16'h0, 1'b1, 4'd13, 4'd12, 3'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
        // R2: signed immediate -1, 0 > -1
        '{32'h00000000, 32'h00000000, 16'hFFFF, 1'b0, 4'd14, 4'd8, 3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
        // R2: unsigned immediate 65535, 0 > 65535 false
        '{32'h00000000, 32'h00000000, 16'hFFFF, 1'b0, 4'd14, 4'd0, 3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},
        // R2: immediate ignores op_b and lane field
        '{32'h00000003, 32'hFFFF0000, 16'h0003, 1'b0, 4'd6, 4'd5, 3'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
        // R5: never
        '{32'h00000005, 32'h00000005, 16'h0, 1'b1, 4'd6, 4'd6, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        // R5: always
        '{32'h00000005, 32'h00000005, 16'h0, 1'b1, 4'd6, 4'd6, 3'd7, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},
        // R5: not-equal on equal values
        '{32'h00000005, 32'h00000005, 16'h0, 1'b1, 4'd6, 4'd6, 3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        // R7: OR with inverted source predicate (effective 1)
        '{32'h00000001, 32'h00000002, 16'h0, 1'b1, 4'd6, 4'd6, 3'd4, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7},
        // R7: XOR with effective 1
        '{32'h00000001, 32'h00000002, 16'h0, 1'b1, 4'd6, 4'd6, 3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},
        // R7: code 3 acts as AND, effective predicate 0
        '{32'h00000001, 32'h00000002, 16'h0, 1'b1, 4'd6, 4'd6, 3'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        // R6: OR with effective 0 passes result and complement
        '{32'h00000001, 32'h00000002, 16'h0, 1'b1, 4'd6, 4'd6, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6}
    };

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {valid,t,f} got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_a = v.a; op_b = v.b; imm_b = v.imm; b_is_reg = v.breg;
        sel_a = v.sa; sel_b = v.sb; cond = v.cc; bool_op = v.bop;
        src_pred = v.pr; src_pred_inv = v.pi;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset state", {out_valid, pred_t, pred_f}, 3'b000);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R%0d vector %0d", VEC[i].rq, i),
                {out_valid, pred_t, pred_f}, {1'b1, VEC[i].et, VEC[i].ef});
        end

        // R8: result not visible before the edge, valid for one cycle only
        drive(VEC[11]);
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        chk("R8 not early", {out_valid, pred_t, pred_f}, 3'b010);
        @(negedge clk);
        in_valid = 1'b0;
        drive(VEC[10]);
        chk("R8 due after one edge", {out_valid, pred_t, pred_f}, 3'b110);
        @(negedge clk);
        chk("R8 valid drops", {out_valid, pred_t, pred_f}, 3'b010);

        // R9: idle cycles with opposite-result inputs do not change predicates
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 hold while idle", {out_valid, pred_t, pred_f}, 3'b010);
        end

        // R10: reset in mid-run clears held predicates
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid-run reset", {out_valid, pred_t, pred_f}, 3'b000);

        // R10: request presented during reset is dropped
        drive(VEC[11]);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        chk("R10 request under reset", {out_valid, pred_t, pred_f}, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule